// File: doc/BRIEF.md
# Dual-Alias General Register File

This block holds the integer architectural state of a 64-bit core: thirty-one ordinary registers, a stack pointer, a program counter and a next-instruction address. Index 31 has two meanings. Each access carries its own alias select, and that select decides whether index 31 names the stack pointer or a hard zero. When index 31 names the zero, it reads as zero and accepts no writes. There are two combinational read ports and one write port. Every port carries an access size of 8, 16, 32 or 64 bits. A read returns the low part of the register, either sign-extended or zero-extended to 64 bits. A narrow write zero-fills the bits above its size.

The program-counter part keeps a current PC and a pending next address. A commit strobe moves the pending address into the PC. The pending address then advances by one instruction, unless it is redirected to an absolute target or to the current PC plus a signed offset. A link strobe copies the pending address into register 30, which gives call instructions their return address.

All ports are plain one-cycle signals. Every access completes in the cycle it is presented, so the block never stalls and has no back-pressure.

Top module: `dual_alias_regfile`

## Requirements
- R1: A synchronous active-high reset clears all 31 registers, the stack pointer, the PC and the next-PC to zero.
- R2: A read of index 31 with its alias select low returns zero.
- R3: A write to index 31 with the alias select low is discarded. The stack pointer and every other register keep their values.
- R4: With the alias select high, index 31 reads and writes the stack pointer like any other register.
- R5: A write of size code 0 (8 bits), 1 (16 bits) or 2 (32 bits) stores the low 8, 16 or 32 bits of the data and clears every bit above them. Size code 3 stores all 64 bits.
- R6: A read returns the low 8, 16, 32 or 64 bits (size codes 0 to 3). When the signed flag is set, the value is sign-extended to 64 bits. Otherwise it is zero-extended.
- R7: A write takes effect at the rising clock edge. A read of the same register in the same cycle returns the old value.
- R8: A commit strobe loads the current next-PC into the PC at the clock edge.
- R9: With no redirect, a commit sets next-PC to its previous value plus 4. A cycle with neither commit nor redirect leaves next-PC unchanged.
- R10: An absolute redirect loads its target into next-PC. It takes priority over an offset redirect and over the commit increment.
- R11: An offset redirect with no absolute redirect loads the current PC plus the signed 64-bit offset into next-PC. It takes priority over the commit increment.
- R12: A link strobe writes the current next-PC into register 30. It takes priority over a write-port access to register 30 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_sp_sel | input | 1 | Read port 0: index 31 means stack pointer (1) or zero (0) |
| rd0_size | input | 2 | Read port 0 size code: 0=8, 1=16, 2=32, 3=64 bits |
| rd0_signed | input | 1 | Read port 0 sign-extend flag |
| rd0_data | output | 64 | Read port 0 extended result |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_sp_sel | input | 1 | Read port 1 alias select |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_signed | input | 1 | Read port 1 sign-extend flag |
| rd1_data | output | 64 | Read port 1 extended result |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write port register index |
| wr_sp_sel | input | 1 | Write port alias select |
| wr_size | input | 2 | Write port size code |
| wr_data | input | 64 | Write data |
| pc_abs_en | input | 1 | Redirect next-PC to an absolute target |
| pc_abs_target | input | 64 | Absolute redirect target |
| pc_off_en | input | 1 | Redirect next-PC to PC plus offset |
| pc_offset | input | 64 | Signed redirect offset |
| pc_commit | input | 1 | Copy next-PC into PC |
| link_save | input | 1 | Copy next-PC into register 30 |
| pc_q | output | 64 | Current PC |
| next_pc_q | output | 64 | Pending next-PC |

## Verification
The main stimulus is long streams of random accesses in which index 31 and register 30 appear far more often than other indices. With that bias the zero alias and the stack-pointer alias are exercised against each other, and the link path collides with the write port. Reads and writes use random sizes and signed flags. Byte values with the top bit set separate sign-extension from zero-extension. Writes of all ones separate narrow-write clearing from merging into the old value. Sparse random commits and redirects, sometimes several at once, separate the priority order of absolute target, offset and increment. Directed sequences then pin down each corner, including a read of a register in the same cycle it is written.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  // Mask of the bits an access of the given size covers.
  function automatic logic [63:0] size_mask(input acc_size_e s);
    case (s)
      SZ_BYTE: size_mask = 64'h0000_0000_0000_00FF;
      SZ_HALF: size_mask = 64'h0000_0000_0000_FFFF;
      SZ_WORD: size_mask = 64'h0000_0000_FFFF_FFFF;
      default: size_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5,
  localparam int NREG = 1 << IDX_W
) (
  input  logic [XLEN-1:0]  bank [NREG],
  input  logic [IDX_W-1:0] idx,
  input  logic             sp_sel,
  input  logic [1:0]       size,
  input  logic             sgn,
  output logic [XLEN-1:0]  data
);
  import rf_pkg::*;
  localparam logic [IDX_W-1:0] ALIAS_IDX = IDX_W'(NREG - 1);

  logic [XLEN-1:0] raw, keep;
  logic            top_bit;

  always_comb begin
    raw  = (idx == ALIAS_IDX && !sp_sel) ? '0 : bank[idx];
    keep = XLEN'(size_mask(acc_size_e'(size)));
    case (acc_size_e'(size))
      SZ_BYTE: top_bit = raw[7];
      SZ_HALF: top_bit = raw[15];
      SZ_WORD: top_bit = raw[31];
      default: top_bit = raw[XLEN-1];
    endcase
    data = (raw & keep) | ((sgn && top_bit) ? ~keep : '0);
  end
endmodule

// File: rtl/rf_write_prep.sv
module rf_write_prep #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5,
  localparam int NREG = 1 << IDX_W
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  input  logic             sp_sel,
  input  logic [1:0]       size,
  input  logic [XLEN-1:0]  data,
  output logic [NREG-1:0]  hit,
  output logic [XLEN-1:0]  wdata
);
  import rf_pkg::*;
  localparam logic [IDX_W-1:0] ALIAS_IDX = IDX_W'(NREG - 1);

  logic live;

  always_comb begin
    live  = en && !(idx == ALIAS_IDX && !sp_sel);
    wdata = data & XLEN'(size_mask(acc_size_e'(size)));
    hit   = '0;
    for (int r = 0; r < NREG; r++)
      hit[r] = live && (idx == IDX_W'(r));
  end
endmodule

// File: rtl/rf_pc_seq.sv
module rf_pc_seq #(
  parameter int XLEN = 64,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abs_en,
  input  logic [XLEN-1:0] abs_target,
  input  logic            off_en,
  input  logic [XLEN-1:0] offset,
  input  logic            commit,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] next_q
);
  logic [XLEN-1:0] next_d;

  always_comb begin
    if (abs_en)      next_d = abs_target;
    else if (off_en) next_d = pc_q + offset;
    else if (commit) next_d = next_q + XLEN'(STEP);
    else             next_d = next_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      next_q <= '0;
    end else begin
      if (commit) pc_q <= next_q;
      next_q <= next_d;
    end
  end
endmodule

// File: rtl/dual_alias_regfile.sv
module dual_alias_regfile #(
  parameter int XLEN     = 64,
  parameter int IDX_W    = 5,
  parameter int LINK_IDX = 30,
  parameter int STEP     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic             rd0_sp_sel,
  input  logic [1:0]       rd0_size,
  input  logic             rd0_signed,
  output logic [XLEN-1:0]  rd0_data,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic             rd1_sp_sel,
  input  logic [1:0]       rd1_size,
  input  logic             rd1_signed,
  output logic [XLEN-1:0]  rd1_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_sp_sel,
  input  logic [1:0]       wr_size,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             pc_abs_en,
  input  logic [XLEN-1:0]  pc_abs_target,
  input  logic             pc_off_en,
  input  logic [XLEN-1:0]  pc_offset,
  input  logic             pc_commit,
  input  logic             link_save,
  output logic [XLEN-1:0]  pc_q,
  output logic [XLEN-1:0]  next_pc_q
);
  localparam int NREG    = 1 << IDX_W;
  localparam int ZR_IDX  = NREG - 1;

  logic [XLEN-1:0] bank_q [NREG];
  logic [NREG-1:0] wr_hit;
  logic [XLEN-1:0] wr_val;

  rf_write_prep #(.XLEN(XLEN), .IDX_W(IDX_W)) wprep_i (
    .en(wr_en), .idx(wr_idx), .sp_sel(wr_sp_sel), .size(wr_size),
    .data(wr_data), .hit(wr_hit), .wdata(wr_val)
  );

  // One storage element per index; the link register adds the link path.
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == LINK_IDX) begin : g_link
      always_ff @(posedge clk) begin
        if (rst)            bank_q[g] <= '0;
        else if (link_save) bank_q[g] <= next_pc_q;
        else if (wr_hit[g]) bank_q[g] <= wr_val;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)            bank_q[g] <= '0;
        else if (wr_hit[g]) bank_q[g] <= wr_val;
      end
    end
  end

  rf_read_port #(.XLEN(XLEN), .IDX_W(IDX_W)) rport0_i (
    .bank(bank_q), .idx(rd0_idx), .sp_sel(rd0_sp_sel),
    .size(rd0_size), .sgn(rd0_signed), .data(rd0_data)
  );

  rf_read_port #(.XLEN(XLEN), .IDX_W(IDX_W)) rport1_i (
    .bank(bank_q), .idx(rd1_idx), .sp_sel(rd1_sp_sel),
    .size(rd1_size), .sgn(rd1_signed), .data(rd1_data)
  );

  rf_pc_seq #(.XLEN(XLEN), .STEP(STEP)) pcseq_i (
    .clk(clk), .rst(rst), .abs_en(pc_abs_en), .abs_target(pc_abs_target),
    .off_en(pc_off_en), .offset(pc_offset), .commit(pc_commit),
    .pc_q(pc_q), .next_q(next_pc_q)
  );
endmodule

// File: rtl/rf_chk.sv
module rf_chk #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5,
  parameter int STEP  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] rd0_idx,
  input logic             rd0_sp_sel,
  input logic [XLEN-1:0]  rd0_data,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_sp_sel,
  input logic             pc_abs_en,
  input logic [XLEN-1:0]  pc_abs_target,
  input logic             pc_off_en,
  input logic [XLEN-1:0]  pc_offset,
  input logic             pc_commit,
  input logic             link_save,
  input logic [XLEN-1:0]  pc_q,
  input logic [XLEN-1:0]  next_pc_q,
  input logic [XLEN-1:0]  lr_q,
  input logic [XLEN-1:0]  sp_q
);
  localparam logic [IDX_W-1:0] TOP_IDX = '1;

  // R2
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx == TOP_IDX && !rd0_sp_sel) |-> rd0_data == '0);

  // R3
  zero_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == TOP_IDX && !wr_sp_sel) |=> $stable(sp_q));

  // R8
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    pc_commit |=> pc_q == $past(next_pc_q));

  // R9
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_commit && !pc_abs_en && !pc_off_en) |=>
      next_pc_q == $past(next_pc_q) + XLEN'(STEP));

  // R10
  abs_win_chk: assert property (@(posedge clk) disable iff (rst)
    pc_abs_en |=> next_pc_q == $past(pc_abs_target));

  // R11
  offset_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_off_en && !pc_abs_en) |=> next_pc_q == $past(pc_q) + $past(pc_offset));

  // R12
  link_save_chk: assert property (@(posedge clk) disable iff (rst)
    link_save |=> lr_q == $past(next_pc_q));
endmodule

bind dual_alias_regfile rf_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .STEP(STEP)) chk_i (
  .clk(clk), .rst(rst), .rd0_idx(rd0_idx), .rd0_sp_sel(rd0_sp_sel),
  .rd0_data(rd0_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sp_sel(wr_sp_sel),
  .pc_abs_en(pc_abs_en), .pc_abs_target(pc_abs_target), .pc_off_en(pc_off_en),
  .pc_offset(pc_offset), .pc_commit(pc_commit), .link_save(link_save),
  .pc_q(pc_q), .next_pc_q(next_pc_q), .lr_q(bank_q[LINK_IDX]),
  .sp_q(bank_q[ZR_IDX])
);

// File: tb/dual_alias_regfile_tb_top.sv
module dual_alias_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd0_idx, rd1_idx, wr_idx;
  logic        rd0_sp_sel, rd1_sp_sel, wr_sp_sel;
  logic [1:0]  rd0_size, rd1_size, wr_size;
  logic        rd0_signed, rd1_signed, wr_en;
  logic [63:0] rd0_data, rd1_data, wr_data;
  logic        pc_abs_en, pc_off_en, pc_commit, link_save;
  logic [63:0] pc_abs_target, pc_offset, pc_q, next_pc_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic [63:0] m_reg [32];
  logic [63:0] m_pc, m_next;
  string next_tag = "R9";
  string phase_tag = "";

  always #5 clk = ~clk;

  dual_alias_regfile dut_i (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_sp_sel(rd0_sp_sel), .rd0_size(rd0_size),
    .rd0_signed(rd0_signed), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_sp_sel(rd1_sp_sel), .rd1_size(rd1_size),
    .rd1_signed(rd1_signed), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sp_sel(wr_sp_sel),
    .wr_size(wr_size), .wr_data(wr_data),
    .pc_abs_en(pc_abs_en), .pc_abs_target(pc_abs_target),
    .pc_off_en(pc_off_en), .pc_offset(pc_offset),
    .pc_commit(pc_commit), .link_save(link_save),
    .pc_q(pc_q), .next_pc_q(next_pc_q)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] m_read(input logic [4:0] idx, input logic sp,
                                         input logic [1:0] sz, input logic sg);
    logic [63:0] v;
    v = (idx == 5'd31 && !sp) ? 64'd0 : m_reg[idx];
    case (sz)
      2'd0: m_read = sg ? 64'($signed(v[7:0]))  : 64'(v[7:0]);
      2'd1: m_read = sg ? 64'($signed(v[15:0])) : 64'(v[15:0]);
      2'd2: m_read = sg ? 64'($signed(v[31:0])) : 64'(v[31:0]);
      default: m_read = v;
    endcase
  endfunction

  function automatic string rd_tag(input logic [4:0] idx, input logic sp, input logic [1:0] sz);
    if (phase_tag != "")        return phase_tag;
    if (idx == 5'd31 && !sp)    return "R2";
    if (idx == 5'd31)           return "R4";
    if (sz != 2'd3)             return "R6";
    return "R7";
  endfunction

  task automatic idle();
    rd0_idx = 0; rd0_sp_sel = 0; rd0_size = 3; rd0_signed = 0;
    rd1_idx = 0; rd1_sp_sel = 0; rd1_size = 3; rd1_signed = 0;
    wr_en = 0; wr_idx = 0; wr_sp_sel = 0; wr_size = 3; wr_data = 0;
    pc_abs_en = 0; pc_abs_target = 0; pc_off_en = 0; pc_offset = 0;
    pc_commit = 0; link_save = 0;
  endtask

  // Compare outputs with the model, then advance the model across the next edge.
  task automatic cycle();
    logic [63:0] nx;
    #1;
    chk(rd_tag(rd0_idx, rd0_sp_sel, rd0_size), rd0_data,
        m_read(rd0_idx, rd0_sp_sel, rd0_size, rd0_signed));
    chk(rd_tag(rd1_idx, rd1_sp_sel, rd1_size), rd1_data,
        m_read(rd1_idx, rd1_sp_sel, rd1_size, rd1_signed));
    chk((phase_tag != "") ? phase_tag : "R8", pc_q, m_pc);
    chk((phase_tag != "") ? phase_tag : next_tag, next_pc_q, m_next);
    if (pc_abs_en)      nx = pc_abs_target;
    else if (pc_off_en) nx = m_pc + pc_offset;
    else if (pc_commit) nx = m_next + 64'd4;
    else                nx = m_next;
    next_tag = pc_abs_en ? "R10" : (pc_off_en ? "R11" : "R9");
    if (wr_en && !(wr_idx == 5'd31 && !wr_sp_sel)) begin
      case (wr_size)
        2'd0: m_reg[wr_idx] = 64'(wr_data[7:0]);
        2'd1: m_reg[wr_idx] = 64'(wr_data[15:0]);
        2'd2: m_reg[wr_idx] = 64'(wr_data[31:0]);
        default: m_reg[wr_idx] = wr_data;
      endcase
    end
    if (link_save) m_reg[30] = m_next;
    if (pc_commit) m_pc = m_next;
    m_next = nx;
  endtask

  function automatic logic [4:0] pick_idx();
    int r = $urandom % 8;
    if (r < 2) return 5'd31;
    if (r == 2) return 5'd30;
    return 5'($urandom % 32);
  endfunction

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] keep_sp, keep_next;
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0; m_next = '0;

    // R1: every register and both PC values cleared by reset
    phase_tag = "R1";
    for (int i = 0; i < 32; i += 2) begin
      @(negedge clk); idle();
      rd0_idx = 5'(i); rd0_sp_sel = 1; rd1_idx = 5'(i + 1); rd1_sp_sel = 1;
      cycle();
    end
    phase_tag = "";

    // Random streams
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); idle();
      rd0_idx = pick_idx(); rd0_sp_sel = 1'($urandom); rd0_size = 2'($urandom);
      rd0_signed = 1'($urandom);
      rd1_idx = pick_idx(); rd1_sp_sel = 1'($urandom); rd1_size = 2'($urandom);
      rd1_signed = 1'($urandom);
      wr_en = ($urandom % 4) != 0; wr_idx = pick_idx(); wr_sp_sel = 1'($urandom);
      wr_size = 2'($urandom);
      wr_data = ($urandom % 4 == 0) ? '1 : {$urandom, $urandom};
      pc_commit = ($urandom % 3) == 0;
      pc_abs_en = ($urandom % 8) == 0; pc_abs_target = {$urandom, $urandom};
      pc_off_en = ($urandom % 6) == 0; pc_offset = 64'($signed(32'($urandom)));
      link_save = ($urandom % 8) == 0;
      cycle();
    end

    // R5: 32-bit write of all ones clears the upper half
    @(negedge clk); idle(); wr_en = 1; wr_idx = 5; wr_size = 2; wr_data = '1; cycle();
    @(negedge clk); idle(); rd0_idx = 5; rd0_size = 3; cycle();
    chk("R5", rd0_data, 64'h0000_0000_FFFF_FFFF);

    // R6: sign versus zero extension of a byte with its top bit set
    @(negedge clk); idle(); wr_en = 1; wr_idx = 9; wr_size = 3; wr_data = 64'h1234_5678_9ABC_DE80; cycle();
    @(negedge clk); idle(); rd0_idx = 9; rd0_size = 0; rd0_signed = 1;
    rd1_idx = 9; rd1_size = 0; rd1_signed = 0; cycle();
    chk("R6", rd0_data, 64'hFFFF_FFFF_FFFF_FF80);
    chk("R6", rd1_data, 64'h0000_0000_0000_0080);

    // R4: stack pointer through index 31 with alias select high
    @(negedge clk); idle(); wr_en = 1; wr_idx = 31; wr_sp_sel = 1; wr_data = 64'hABCD; cycle();
    @(negedge clk); idle(); rd0_idx = 31; rd0_sp_sel = 1; cycle();
    chk("R4", rd0_data, 64'hABCD);

    // R3: zero-alias write leaves the stack pointer untouched
    @(negedge clk); idle(); wr_en = 1; wr_idx = 31; wr_sp_sel = 0; wr_data = 64'h1111; cycle();
    @(negedge clk); idle(); rd0_idx = 31; rd0_sp_sel = 1; rd1_idx = 31; cycle();
    chk("R3", rd0_data, 64'hABCD);
    chk("R2", rd1_data, 64'h0);

    // R7: same-cycle read sees the old value, next cycle the new one
    @(negedge clk); idle(); wr_en = 1; wr_idx = 7; wr_data = 64'h7777; cycle();
    @(negedge clk); idle(); wr_en = 1; wr_idx = 7; wr_data = 64'h8888; rd0_idx = 7; cycle();
    chk("R7", rd0_data, 64'h7777);
    @(negedge clk); idle(); rd0_idx = 7; cycle();
    chk("R7", rd0_data, 64'h8888);

    // R10: absolute target beats offset and increment together
    @(negedge clk); idle(); pc_abs_en = 1; pc_abs_target = 64'h4000; pc_off_en = 1;
    pc_offset = 64'h10; pc_commit = 1; cycle();
    @(negedge clk); idle(); cycle();
    chk("R10", next_pc_q, 64'h4000);

    // R8 / R9: commit installs 0x4000 and steps to 0x4004
    @(negedge clk); idle(); pc_commit = 1; cycle();
    @(negedge clk); idle(); cycle();
    chk("R8", pc_q, 64'h4000);
    chk("R9", next_pc_q, 64'h4004);

    // R11: negative offset from the current PC
    @(negedge clk); idle(); pc_off_en = 1; pc_offset = -64'sd16; pc_commit = 1; cycle();
    @(negedge clk); idle(); cycle();
    chk("R11", next_pc_q, 64'h3FF0);

    // R12: link strobe beats a write-port access to register 30
    keep_next = m_next;
    @(negedge clk); idle(); link_save = 1; wr_en = 1; wr_idx = 30; wr_data = 64'h55; cycle();
    @(negedge clk); idle(); rd0_idx = 30; cycle();
    chk("R12", rd0_data, keep_next);
    keep_sp = m_reg[31];
    chk("R4", keep_sp, 64'hABCD);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule